// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Timing

This block sits between a processor's 28-bit address and eight memory or peripheral banks. Each bank is described by one 32-bit configuration word. The word holds a base address, a power-of-two size, an enable, a wait-enable and two sets of four-phase timing, one for reads and one for writes. When an access request arrives, the block compares the address with every enabled bank. It then drives the active-low select of the winning bank and runs the access through setup, strobe, hold and recovery phases. Near the end of the strobe phase it raises a one-cycle transfer acknowledge of its own, so the processor needs no external acknowledge logic.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the address and attributes steady until that edge. While an access or its recovery time is running, `req_ready` stays low and the request waits. A request that matches no bank is taken and dropped. Bank timing is captured when a request is taken, so a configuration write made during an access affects only later accesses.

The configuration word is laid out as follows:
- [9:0]: base, compared with address bits 27:18.
- [13:10]: size code.
- [14]: enable.
- [15]: wait-enable.
- [23:16]: read timing.
- [31:24]: write timing.

Each timing byte is split into four 2-bit counts: setup in [1:0], access wait states in [3:2], hold in [5:4] and recovery in [7:6].

Top module: `csel_unit`

## Requirements
- R1: After reset, bank 0 holds the word 0xFFFF5400: base 0, size code 5 (8 MB), enabled, wait-enable clear, every timing count 3. Banks 1 to 7 hold 0 and are disabled. All selects and strobes are high, `xfer_ack` is low and `req_ready` is high.
- R2: A pulse on `cfg_we` loads `cfg_wdata` into the bank chosen by `cfg_idx`, using the field layout above, from the next clock edge onward.
- R3: Size code c gives a bank of 256 KB shifted left by c. Only address bits 27 down to 18+c are compared with the matching base bits, and codes above 8 act as 8 (64 MB).
- R4: If several enabled banks match, the lowest-numbered one is selected, and at most one `cs_n` bit is ever low.
- R5: A taken access runs these phases, using the read byte for reads and the write byte for writes: setup for s clocks (select low, strobes high), then strobe for a+1 clocks (select and strobe low), then hold for h clocks (select low, strobes high), then recovery for r clocks (all high, `req_ready` low). The block is idle again in the cycle after that.
- R6: A read drives `rd_n` low during the strobe phase. A write drives `wr_upper_n` low when `req_upper` is set and `wr_lower_n` low when `req_lower` is set.
- R7: `xfer_ack` is high for exactly one cycle per access, in the last strobe cycle.
- R8: When the bank's wait-enable is set, `ext_wait` high in what would be the last strobe cycle extends the strobe phase by one cycle. When wait-enable is clear, `ext_wait` has no effect.
- R9: `req_ready` is high only while idle. A request taken with no matching bank produces no select, no strobe and no acknowledge, and leaves `req_ready` high.
- R10: A bank whose enable bit is 0 is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Bank to write |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Decoder idle and able to take a request |
| req_addr | input | 28 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_upper | input | 1 | Upper byte lane written |
| req_lower | input | 1 | Lower byte lane written |
| ext_wait | input | 1 | Stretches the strobe phase of wait-enabled banks |
| cs_n | output | 8 | Active-low bank selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_upper_n | output | 1 | Active-low upper-lane write strobe |
| wr_lower_n | output | 1 | Active-low lower-lane write strobe |
| xfer_ack | output | 1 | One-cycle transfer acknowledge |

## Verification
Directed addresses are placed on both sides of a bank's top edge. This separates the compare widths implied by different size codes, including codes above 8. Overlapping banks, with one of them later disabled, show whether priority and the enable bit are honoured. Fixed timing bytes with zero and nonzero counts, plus `ext_wait` held for several cycles with wait-enable set and then clear, tell the read and write timing sets apart and show whether the stall is gated. Seeded random configuration words, addresses, lanes and wait lengths then cross all of these against a cycle-by-cycle expected trace.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  localparam int ADDR_W    = 28;
  localparam int MIN_SHIFT = 18;
  localparam int BASE_W    = ADDR_W - MIN_SHIFT;
  localparam int CODE_W    = 4;
  localparam int MAX_CODE  = 8;
  localparam int PH_W      = 2;

  typedef struct packed {
    logic [PH_W-1:0] rec;
    logic [PH_W-1:0] hold;
    logic [PH_W-1:0] acc;
    logic [PH_W-1:0] setup;
  } phase_t;

  typedef struct packed {
    phase_t              wr;
    phase_t              rd;
    logic                wait_en;
    logic                en;
    logic [CODE_W-1:0]   code;
    logic [BASE_W-1:0]   base;
  } bank_cfg_t;

  localparam bank_cfg_t BOOT_BANK0 = bank_cfg_t'(32'hFFFF_5400);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_ACC, ST_HOLD, ST_REC} seq_st_t;
endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs
  import csel_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int CFG_W = $bits(bank_cfg_t)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [CFG_W-1:0]            cfg_wdata,
  output bank_cfg_t [N_BANKS-1:0]     cfg_o
);
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam bank_cfg_t RST_VAL = (b == 0) ? BOOT_BANK0 : bank_cfg_t'('0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_o[b] <= RST_VAL;
      else if (cfg_we && cfg_idx == IDX_W'(b))
        cfg_o[b] <= bank_cfg_t'(cfg_wdata);
    end
  end
endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match
  import csel_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  bank_cfg_t [N_BANKS-1:0]  cfg,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic [N_BANKS-1:0] bank_hit;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_cmp
    logic [CODE_W-1:0] code_c;
    logic [BASE_W-1:0] keep;
    always_comb begin
      code_c = (cfg[b].code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : cfg[b].code;
      keep   = {BASE_W{1'b1}} << code_c;
      bank_hit[b] = cfg[b].en &&
                    (((addr[ADDR_W-1:MIN_SHIFT] ^ cfg[b].base) & keep) == '0);
    end
  end

  // Scan from the top so the lowest matching bank is the last to be written.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int b = N_BANKS - 1; b >= 0; b--) begin
      if (bank_hit[b]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(b);
      end
    end
  end

  // R4 / R10: the chosen bank really matched and no lower bank matched.
  always_comb begin
    if (hit) begin
      a_r4_lowest_wins: assert (bank_hit[hit_idx] &&
                                ((bank_hit & ((N_BANKS'(1) << hit_idx) - N_BANKS'(1))) == '0));
    end
  end
endmodule

// File: rtl/csel_seq.sv
`timescale 1ns/1ps
module csel_seq
  import csel_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   start_idx,
  input  phase_t             start_tim,
  input  logic               start_wait_en,
  input  logic               start_write,
  input  logic               start_upper,
  input  logic               start_lower,
  input  logic               ext_wait,
  output logic               busy,
  output logic [N_BANKS-1:0] cs_n,
  output logic               rd_n,
  output logic               wr_upper_n,
  output logic               wr_lower_n,
  output logic               ack
);
  localparam logic [N_BANKS-1:0] ONE = N_BANKS'(1);

  seq_st_t         st;
  logic [PH_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  phase_t          tim_q;
  logic            wen_q, wr_q, up_q, lo_q;
  logic            stall, sel_on, strobe_on;

  assign stall     = wen_q && ext_wait;
  assign sel_on    = (st == ST_SETUP) || (st == ST_ACC) || (st == ST_HOLD);
  assign strobe_on = (st == ST_ACC);
  assign busy      = (st != ST_IDLE);
  assign ack       = strobe_on && (cnt == '0) && !stall;
  assign cs_n       = sel_on ? ~(ONE << idx_q) : '1;
  assign rd_n       = !(strobe_on && !wr_q);
  assign wr_upper_n = !(strobe_on && wr_q && up_q);
  assign wr_lower_n = !(strobe_on && wr_q && lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      idx_q <= '0;
      tim_q <= '0;
      wen_q <= 1'b0;
      wr_q  <= 1'b0;
      up_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          idx_q <= start_idx;
          tim_q <= start_tim;
          wen_q <= start_wait_en;
          wr_q  <= start_write;
          up_q  <= start_upper;
          lo_q  <= start_lower;
          if (start_tim.setup != '0) begin
            st  <= ST_SETUP;
            cnt <= start_tim.setup - 2'd1;
          end else begin
            st  <= ST_ACC;
            cnt <= start_tim.acc;
          end
        end
        ST_SETUP: if (cnt == '0) begin
          st  <= ST_ACC;
          cnt <= tim_q.acc;
        end else cnt <= cnt - 2'd1;
        ST_ACC: if (cnt != '0) cnt <= cnt - 2'd1;
          else if (!stall) begin
            if (tim_q.hold != '0) begin
              st  <= ST_HOLD;
              cnt <= tim_q.hold - 2'd1;
            end else if (tim_q.rec != '0) begin
              st  <= ST_REC;
              cnt <= tim_q.rec - 2'd1;
            end else st <= ST_IDLE;
          end
        ST_HOLD: if (cnt == '0) begin
          if (tim_q.rec != '0) begin
            st  <= ST_REC;
            cnt <= tim_q.rec - 2'd1;
          end else st <= ST_IDLE;
        end else cnt <= cnt - 2'd1;
        ST_REC: if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 2'd1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: an acknowledge is never followed directly by another one.
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R8: a stalled final strobe cycle keeps the strobe asserted next cycle.
  a_r8_stall_keeps_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && cnt == '0 && stall) |=> (strobe_on && $stable(idx_q)));
  // R5: the select is released only after the strobe has ended.
  a_r5_select_outlives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !ack) |=> sel_on);
endmodule

// File: rtl/csel_unit.sv
`timescale 1ns/1ps
module csel_unit
  import csel_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int CFG_W = $bits(bank_cfg_t)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic               req_upper,
  input  logic               req_lower,
  input  logic               ext_wait,
  output logic [N_BANKS-1:0] cs_n,
  output logic               rd_n,
  output logic               wr_upper_n,
  output logic               wr_lower_n,
  output logic               xfer_ack
);
  bank_cfg_t [N_BANKS-1:0] cfg;
  logic                    hit;
  logic [IDX_W-1:0]        hit_idx;
  logic                    busy, accept;
  phase_t                  sel_tim;

  csel_regs #(.N_BANKS(N_BANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_o(cfg)
  );

  csel_match #(.N_BANKS(N_BANKS)) u_match (
    .addr(req_addr), .cfg(cfg), .hit(hit), .hit_idx(hit_idx)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign sel_tim   = req_write ? cfg[hit_idx].wr : cfg[hit_idx].rd;

  csel_seq #(.N_BANKS(N_BANKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept && hit), .start_idx(hit_idx), .start_tim(sel_tim),
    .start_wait_en(cfg[hit_idx].wait_en), .start_write(req_write),
    .start_upper(req_upper), .start_lower(req_lower), .ext_wait(ext_wait),
    .busy(busy), .cs_n(cs_n), .rd_n(rd_n), .wr_upper_n(wr_upper_n),
    .wr_lower_n(wr_lower_n), .ack(xfer_ack)
  );

  // R4: never more than one select low.
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R6: a strobe is only driven while some bank is selected.
  a_r6_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_upper_n || !wr_lower_n) |-> (cs_n != '1));
  // R9: a taken request that matches nothing leaves the bus idle.
  a_r9_miss_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (req_ready && cs_n == '1 && !xfer_ack));
  // R9: while an access runs, nothing else is taken.
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> !req_ready);
endmodule

// File: tb/tb_csel_unit.sv
`timescale 1ns/1ps
module tb_csel_unit;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready, req_write, req_upper, req_lower, ext_wait;
  logic [27:0] req_addr;
  logic [NB-1:0] cs_n;
  logic        rd_n, wr_upper_n, wr_lower_n, xfer_ack;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [NB];

  always #2.5 clk = ~clk;

  csel_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_upper(req_upper), .req_lower(req_lower),
    .ext_wait(ext_wait), .cs_n(cs_n), .rd_n(rd_n), .wr_upper_n(wr_upper_n),
    .wr_lower_n(wr_lower_n), .xfer_ack(xfer_ack)
  );

  function automatic logic [31:0] mk(logic [9:0] base, logic [3:0] code, logic en,
                                     logic wen, logic [7:0] rd, logic [7:0] wr);
    return {wr, rd, wen, en, code, base};
  endfunction

  function automatic int find_bank(logic [27:0] a);
    for (int b = 0; b < NB; b++) begin
      int code = int'(shadow[b][13:10]);
      logic [9:0] keep;
      if (code > 8) code = 8;
      keep = 10'h3FF << code;
      if (shadow[b][14] && (((a[27:18] ^ shadow[b][9:0]) & keep) == 10'h0)) return b;
    end
    return -1;
  endfunction

  task automatic chk(string req, logic [NB-1:0] e_cs, logic e_rd, logic e_wu,
                     logic e_wl, logic e_ack, logic e_rdy);
    checks++;
    if (cs_n !== e_cs || rd_n !== e_rd || wr_upper_n !== e_wu || wr_lower_n !== e_wl ||
        xfer_ack !== e_ack || req_ready !== e_rdy) begin
      errors++;
      $display("FAIL %s actual cs_n=%b rd=%b wu=%b wl=%b ack=%b rdy=%b expected cs_n=%b rd=%b wu=%b wl=%b ack=%b rdy=%b",
               req, cs_n, rd_n, wr_upper_n, wr_lower_n, xfer_ack, req_ready,
               e_cs, e_rd, e_wu, e_wl, e_ack, e_rdy);
    end
  endtask

  task automatic wcfg(int b, logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(b); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[b] = w;
  endtask

  task automatic run_access(string req, logic [27:0] addr, logic wr, logic up,
                            logic lo, int wait_len);
    int b, s, a, h, r, acc_len, total;
    logic [7:0] ph;
    logic wen;
    b = find_bank(addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_upper = up; req_lower = lo;
    ext_wait = 1'b0;
    #1 chk(req, '1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    if (b < 0) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1 chk(req, '1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      return;
    end
    ph  = wr ? shadow[b][31:24] : shadow[b][23:16];
    wen = shadow[b][15];
    s = int'(ph[1:0]); a = int'(ph[3:2]); h = int'(ph[5:4]); r = int'(ph[7:6]);
    acc_len = (wen && wait_len > a) ? wait_len + 1 : a + 1;
    total = s + acc_len + h + r;
    for (int c = 0; c <= total; c++) begin
      logic in_sel, in_acc;
      @(negedge clk);
      req_valid = 1'b0;
      ext_wait = (c >= s) && (c - s < wait_len);
      #1;
      in_acc = (c >= s) && (c < s + acc_len);
      in_sel = (c < s + acc_len + h);
      chk(req, in_sel ? ~(NB'(1) << b) : '1,
          !(in_acc && !wr), !(in_acc && wr && up), !(in_acc && wr && lo),
          (c == s + acc_len - 1), (c == total));
    end
    ext_wait = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_upper = 1'b0;
    req_lower = 1'b0; ext_wait = 1'b0;
    shadow[0] = 32'hFFFF_5400;
    for (int b = 1; b < NB; b++) shadow[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset idle", '1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);

    run_access("R1 boot bank0 read", 28'h000_0100, 1'b0, 1'b0, 1'b0, 0);
    run_access("R6 boot bank0 upper write", 28'h07F_FFFE, 1'b1, 1'b1, 1'b0, 0);
    run_access("R9 R1 miss above 8MB", 28'h080_0000, 1'b0, 1'b0, 1'b0, 0);
    run_access("R10 banks disabled at reset", 28'h400_0000, 1'b1, 1'b1, 1'b1, 0);

    // R2 R3: 256 KB bank at 0x2000000, read s1 a0, write a2 h1 r2
    wcfg(1, mk(10'h080, 4'd0, 1'b1, 1'b0, 8'h01, 8'h98));
    run_access("R3 R5 small bank top read", 28'h203_FFFF, 1'b0, 1'b0, 1'b0, 0);
    run_access("R3 past small bank", 28'h204_0000, 1'b0, 1'b0, 1'b0, 0);
    run_access("R5 R6 write timing lower lane", 28'h200_0010, 1'b1, 1'b0, 1'b1, 0);

    // R8: 64 MB wait-enabled bank at 0x4000000, read a1
    wcfg(2, mk(10'h100, 4'd8, 1'b1, 1'b1, 8'h04, 8'h04));
    run_access("R8 wait stretches strobe", 28'h7FF_FFF0, 1'b0, 1'b0, 1'b0, 3);
    wcfg(2, mk(10'h100, 4'd8, 1'b1, 1'b0, 8'h04, 8'h04));
    run_access("R8 wait ignored when disabled", 28'h400_0000, 1'b0, 1'b0, 1'b0, 3);

    // R4: overlapping bank 3 loses to bank 2; after bank 2 is disabled it wins
    wcfg(3, mk(10'h100, 4'd0, 1'b1, 1'b0, 8'h55, 8'h55));
    run_access("R4 lowest bank wins", 28'h400_0004, 1'b1, 1'b1, 1'b1, 0);
    wcfg(2, mk(10'h100, 4'd8, 1'b0, 1'b0, 8'h04, 8'h04));
    run_access("R10 R4 disabled bank skipped", 28'h400_0004, 1'b0, 1'b0, 1'b0, 0);
    run_access("R10 disabled bank upper area", 28'h500_0000, 1'b0, 1'b0, 1'b0, 0);

    // R3: code above 8 acts as 64 MB
    wcfg(4, mk(10'h200, 4'd15, 1'b1, 1'b0, 8'h00, 8'h00));
    run_access("R3 clamped code inside", 28'hBFF_FFFF, 1'b0, 1'b0, 1'b0, 0);
    run_access("R3 clamped code outside", 28'hC00_0000, 1'b0, 1'b0, 1'b0, 0);

    for (int i = 0; i < 250; i++) begin
      logic [27:0] addr;
      int b, code;
      if (i % 16 == 0) wcfg(int'($urandom % NB), $urandom);
      if ($urandom % 4 != 0) begin
        b = int'($urandom % NB);
        code = int'(shadow[b][13:10]);
        if (code > 8) code = 8;
        addr = {shadow[b][9:0], 18'h0} ^ (28'($urandom) & ((28'd1 << (18 + code)) - 28'd1));
      end else addr = 28'($urandom);
      run_access("R5 R7 random access", addr, 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 5));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule